// File: doc/BRIEF.md
# Compare-Clear Interval Timer

An up-counting timer that advances by one on every cycle in which its clock-enable tick is high. A prescaler outside the block supplies that tick. In free-running operation the counter wraps from its all-ones value back to zero. In compare-clear operation the counter returns to zero on the tick after it equals a compare register, so the compare value sets the period.

Software can load the counter and the compare register directly. A compare register write takes effect at once, because the register has no shadow copy.

Two sticky event flags record an overflow and a compare match. Software clears a flag by writing a one to its bit, or by pulsing the matching acknowledge input. A waveform pin can be set, cleared or toggled on each match, as a two-bit action field selects.

Top module: `cmpTimer`

## Requirements
- R1: After reset, count is 0, compare is all ones (0xFF), both flags are 0 and waveOut is 0.
- R2: With modeSel 0, 1 or 3, each cycle with tick high increments count, wrapping from 0xFF to 0x00, and a compare match never clears the counter. With tick low, count holds.
- R3: ovfFlag becomes 1 after a tick taken while count is 0xFF and no counter write is requested. This applies in every mode. Hardware never clears ovfFlag.
- R4: With modeSel 2, a tick taken while count equals compare loads 0 into count instead of incrementing it.
- R5: cmpFlag becomes 1 after a tick taken while count equals compare and no counter write is requested. This applies in every mode.
- R6: A compare write is used from the next cycle on. If it lowers compare below count in modeSel 2, the counter runs on to 0xFF, wraps to 0 with ovfFlag set, and then clears at the new value.
- R7: cntWrEn loads cntWrData in that cycle whether or not tick is high. It takes priority over counting, and it suppresses both the match and the overflow for that cycle.
- R8: The action codes on actSel are as follows.
  - 0: waveOut is held at 0 and the internal pin state is kept.
  - 1: each match toggles the pin.
  - 2: each match clears the pin.
  - 3: each match sets the pin.
  - The action code never changes the counting sequence.
- R9: A flag is cleared when flagWrEn is high with a 1 in its bit of flagWrData (bit 0 is overflow, bit 1 is compare match). It is also cleared by a pulse on ovfAck or cmpAck. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from external prescaler |
| modeSel | input | 2 | 0 free-run, 2 compare-clear, 1/3 act as 0 |
| actSel | input | 2 | Match action for waveform pin |
| cntWrEn | input | 1 | Load counter strobe |
| cntWrData | input | WIDTH | Counter load value |
| cmpWrEn | input | 1 | Load compare strobe |
| cmpWrData | input | WIDTH | Compare load value |
| flagWrEn | input | 1 | Write-one-to-clear strobe for flags |
| flagWrData | input | 2 | Bit 0 overflow, bit 1 compare |
| ovfAck | input | 1 | Clears overflow flag |
| cmpAck | input | 1 | Clears compare flag |
| count | output | WIDTH | Counter value |
| compare | output | WIDTH | Compare register |
| ovfFlag | output | 1 | Overflow flag |
| cmpFlag | output | 1 | Compare-match flag |
| waveOut | output | 1 | Waveform pin |

## Verification
The bench builds the block with the default WIDTH of 8. At that width the full counter range is small, so the bench can reach every wrap and every clear-on-compare boundary by loading the counter a few counts below the target and ticking. The case where the compare value is lowered beneath the running count is only practical because of this: it needs a run of under fifty ticks through 0xFF and back up to the new compare value.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PWM_A = 2'd1,
    MODE_CTC   = 2'd2,
    MODE_PWM_B = 2'd3
  } timerMode_e;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } waveAct_e;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_CMP  = 1;

  typedef struct packed {
    logic                 load;
    logic                 clear;
    logic                 incr;
    logic                 cmpLoad;
    logic [NUM_FLAGS-1:0] flagSet;
    logic [NUM_FLAGS-1:0] flagClr;
    logic                 waveSet;
    logic                 waveClr;
    logic                 waveTgl;
    logic                 waveDrive;
  } timerStrobe_t;

endpackage

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [1:0]           modeSel,
  input  logic [1:0]           actSel,
  input  logic                 cntWrEn,
  input  logic                 cmpWrEn,
  input  logic                 flagWrEn,
  input  logic [NUM_FLAGS-1:0] flagWrData,
  input  logic                 ovfAck,
  input  logic                 cmpAck,
  input  logic [WIDTH-1:0]     countQ,
  input  logic [WIDTH-1:0]     compareQ,
  output timerStrobe_t         strb
);

  localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};

  timerMode_e mode;
  waveAct_e   act;
  logic       liveTick;
  logic       isMatch;
  logic       isTop;
  logic       ctcMode;

  assign mode     = timerMode_e'(modeSel);
  assign act      = waveAct_e'(actSel);
  assign ctcMode  = (mode == MODE_CTC);
  assign liveTick = tick && !cntWrEn;
  assign isMatch  = liveTick && (countQ == compareQ);
  assign isTop    = liveTick && (countQ == MAX_COUNT);

  always_comb begin
    strb                   = '0;
    strb.load              = cntWrEn;
    strb.clear             = isMatch && ctcMode;
    strb.incr              = liveTick && !(isMatch && ctcMode);
    strb.cmpLoad           = cmpWrEn;
    strb.flagSet[FLAG_OVF] = isTop;
    strb.flagSet[FLAG_CMP] = isMatch;
    strb.flagClr[FLAG_OVF] = ovfAck || (flagWrEn && flagWrData[FLAG_OVF]);
    strb.flagClr[FLAG_CMP] = cmpAck || (flagWrEn && flagWrData[FLAG_CMP]);
    strb.waveDrive         = (act != ACT_OFF);
    unique case (act)
      ACT_TOGGLE: strb.waveTgl = isMatch;
      ACT_CLEAR:  strb.waveClr = isMatch;
      ACT_SET:    strb.waveSet = isMatch;
      default:    ;
    endcase
  end

  // R2
  count_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.clear, strb.incr}));

  // R7
  load_blocks_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |-> (strb.flagSet == '0 && !strb.waveTgl && !strb.waveSet && !strb.waveClr));

  // R4
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWrEn && modeSel == 2'd2 && countQ == compareQ) |-> strb.clear);

endmodule

// File: rtl/cmpTimerDatapath.sv
module cmpTimerDatapath
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  timerStrobe_t         strb,
  input  logic [WIDTH-1:0]     cntWrData,
  input  logic [WIDTH-1:0]     cmpWrData,
  output logic [WIDTH-1:0]     countQ,
  output logic [WIDTH-1:0]     compareQ,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic                 waveOut
);

  localparam logic [WIDTH-1:0] RESET_CMP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE       = {{(WIDTH-1){1'b0}}, 1'b1};

  logic waveQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.load) begin
      countQ <= cntWrData;
    end else if (strb.clear) begin
      countQ <= '0;
    end else if (strb.incr) begin
      countQ <= countQ + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= RESET_CMP;
    end else if (strb.cmpLoad) begin
      compareQ <= cmpWrData;
    end
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[f] <= 1'b0;
      end else if (strb.flagSet[f]) begin
        flagQ[f] <= 1'b1;
      end else if (strb.flagClr[f]) begin
        flagQ[f] <= 1'b0;
      end
    end

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.flagClr[f] && !strb.flagSet[f]) |=> !flagQ[f]);

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[f] && !strb.flagClr[f]) |=> flagQ[f]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waveQ <= 1'b0;
    end else if (strb.waveSet) begin
      waveQ <= 1'b1;
    end else if (strb.waveClr) begin
      waveQ <= 1'b0;
    end else if (strb.waveTgl) begin
      waveQ <= !waveQ;
    end
  end

  assign waveOut = strb.waveDrive ? waveQ : 1'b0;

  // R2
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> countQ == WIDTH'($past(countQ) + ONE));

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> countQ == $past(cntWrData));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> countQ == '0);

  // R8
  wave_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.waveDrive |-> !waveOut);

endmodule

// File: rtl/cmpTimer.sv
module cmpTimer
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       actSel,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             flagWrEn,
  input  logic [1:0]       flagWrData,
  input  logic             ovfAck,
  input  logic             cmpAck,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] compare,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             waveOut
);

  timerStrobe_t         strb;
  logic [NUM_FLAGS-1:0] flagQ;

  cmpTimerCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .modeSel    (modeSel),
    .actSel     (actSel),
    .cntWrEn    (cntWrEn),
    .cmpWrEn    (cmpWrEn),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .ovfAck     (ovfAck),
    .cmpAck     (cmpAck),
    .countQ     (count),
    .compareQ   (compare),
    .strb       (strb)
  );

  cmpTimerDatapath #(.WIDTH(WIDTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntWrData (cntWrData),
    .cmpWrData (cmpWrData),
    .countQ    (count),
    .compareQ  (compare),
    .flagQ     (flagQ),
    .waveOut   (waveOut)
  );

  assign ovfFlag = flagQ[FLAG_OVF];
  assign cmpFlag = flagQ[FLAG_CMP];

endmodule

// File: tb/tb_cmpTimer.sv
`timescale 1ns/1ps
module tb_cmpTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [1:0] actSel = 2'd0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = '0;
  logic       flagWrEn = 1'b0;
  logic [1:0] flagWrData = '0;
  logic       ovfAck = 1'b0;
  logic       cmpAck = 1'b0;
  logic [7:0] count;
  logic [7:0] compare;
  logic       ovfFlag;
  logic       cmpFlag;
  logic       waveOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmpTimer #(.WIDTH(8)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .modeSel(modeSel), .actSel(actSel),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .ovfAck(ovfAck), .cmpAck(cmpAck), .count(count), .compare(compare),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .waveOut(waveOut)
  );

  typedef struct packed {
    logic       tk;
    logic       cw;
    logic [7:0] cd;
    logic       pw;
    logic [7:0] pd;
    logic [1:0] fw;
    logic [1:0] md;
    logic [1:0] ac;
    logic [7:0] eCount;
    logic       eOvf;
    logic       eCmp;
    logic       eWave;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 8'hFD, 1'b0, 8'h00, 2'b00, 2'd0, 2'd1, 8'hFD, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd0, 2'd1, 8'hFE, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd0, 2'd1, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd0, 2'd1, 8'h00, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 2'b11, 2'd0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd2, 2'd1, 8'h01, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd2, 2'd1, 8'h02, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd2, 2'd1, 8'h03, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 2'd2, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    cntWrEn = 0; cmpWrEn = 0; flagWrEn = 0; ovfAck = 0; cmpAck = 0; tick = 0;
  endtask

  task automatic loadCount(input logic [7:0] v);
    cntWrEn = 1; cntWrData = v; cycle();
  endtask

  task automatic loadCmp(input logic [7:0] v);
    cmpWrEn = 1; cmpWrData = v; cycle();
  endtask

  task automatic clearFlags();
    flagWrEn = 1; flagWrData = 2'b11; cycle();
  endtask

  task automatic tickOnce();
    tick = 1; cycle();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {count, compare, ovfFlag, cmpFlag, waveOut}, {8'h00, 8'hFF, 3'b000});

    // table walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      tick = VECS[i].tk; cntWrEn = VECS[i].cw; cntWrData = VECS[i].cd;
      cmpWrEn = VECS[i].pw; cmpWrData = VECS[i].pd;
      flagWrEn = |VECS[i].fw; flagWrData = VECS[i].fw;
      modeSel = VECS[i].md; actSel = VECS[i].ac;
      cycle();
      check($sformatf("R2/R4/R5 vector %0d", i), {count, ovfFlag, cmpFlag, waveOut},
            {VECS[i].eCount, VECS[i].eOvf, VECS[i].eCmp, VECS[i].eWave});
    end

    // R2 no tick holds
    loadCount(8'h40);
    cycle(); cycle(); cycle();
    check("R2 hold without tick", count, 8'h40);

    // R2 R3 mode 3 wraps and sets overflow
    modeSel = 2'd3; loadCmp(8'h10); clearFlags(); loadCount(8'hFE);
    tickOnce();
    check("R2 mode3 increment", count, 8'hFF);
    tickOnce();
    check("R3 wrap sets ovf", {count, ovfFlag}, {8'h00, 1'b1});

    // R2 mode 1 match does not clear
    modeSel = 2'd1; clearFlags(); loadCount(8'h10);
    tickOnce();
    check("R2 mode1 no clear on match", {count, cmpFlag}, {8'h11, 1'b1});

    // R7 write with tick suppresses match, then R4 R5
    modeSel = 2'd2; loadCmp(8'h05); clearFlags();
    tick = 1; cntWrEn = 1; cntWrData = 8'h05; cycle();
    check("R7 write blocks match", {count, cmpFlag}, {8'h05, 1'b0});
    tickOnce();
    check("R4 R5 ctc clear", {count, cmpFlag}, {8'h00, 1'b1});

    // R7 write blocks overflow
    loadCount(8'hFF); clearFlags();
    tick = 1; cntWrEn = 1; cntWrData = 8'h10; cycle();
    check("R7 write blocks ovf", {count, ovfFlag}, {8'h10, 1'b0});

    // R6 compare lowered under count
    loadCmp(8'h80); loadCount(8'hF0); loadCmp(8'h20); clearFlags();
    repeat (15) tickOnce();
    check("R6 runs to top", {count, ovfFlag, cmpFlag}, {8'hFF, 2'b00});
    tickOnce();
    check("R6 wrap sets ovf", {count, ovfFlag}, {8'h00, 1'b1});
    repeat (32) tickOnce();
    check("R6 reaches new compare", {count, cmpFlag}, {8'h20, 1'b0});
    tickOnce();
    check("R6 clears at new compare", {count, cmpFlag}, {8'h00, 1'b1});

    // R8 actions
    loadCmp(8'h02); actSel = 2'd3; loadCount(8'h02);
    tickOnce();
    check("R8 set on match", {count, waveOut}, {8'h00, 1'b1});
    actSel = 2'd2; loadCount(8'h02);
    tickOnce();
    check("R8 clear on match", {count, waveOut}, {8'h00, 1'b0});
    actSel = 2'd3; loadCount(8'h02);
    tickOnce();
    actSel = 2'd0; #1;
    check("R8 action 0 forces low", waveOut, 1'b0);
    loadCount(8'h02);
    tickOnce();
    check("R8 action 0 keeps counting", count, 8'h00);
    actSel = 2'd3; #1;
    check("R8 pin state kept", waveOut, 1'b1);

    // R9 flag clearing
    cmpAck = 1; cycle();
    check("R9 cmpAck clears", cmpFlag, 1'b0);
    modeSel = 2'd0; loadCmp(8'hFF); loadCount(8'hFF); clearFlags();
    tickOnce();
    check("R9 both set", {ovfFlag, cmpFlag}, 2'b11);
    flagWrEn = 1; flagWrData = 2'b01; cycle();
    check("R9 write-one bit0 only", {ovfFlag, cmpFlag}, 2'b01);
    loadCount(8'hFF);
    tick = 1; cmpAck = 1; ovfAck = 1; cycle();
    check("R9 set wins over clear", {ovfFlag, cmpFlag}, 2'b11);
    ovfAck = 1; cycle();
    check("R9 ovfAck clears", {ovfFlag, cmpFlag}, 2'b01);
    flagWrEn = 1; flagWrData = 2'b10; cycle();
    check("R9 write-one bit1", {ovfFlag, cmpFlag}, 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule